// File: doc/BRIEF.md
# Clock-Gating Power Sequencer with Host-Access Wake

This block decides when a disk-controller core and its oscillator may be shut down, and brings them back without any change to host software. Software can send a mode command that powers the block down at once. It can also arm automatic entry, in which case the block counts ticks of an always-running slow reference while the core reports idle, and shuts down when the count runs out. The default count stands for half a second at a 1 ms reference tick, which matches the standard data rate.

While powered down, the oscillator enable and the core enable are both low. A host read or write that targets the status register or the data register turns the oscillator back on at once. The core stays disabled, and the host ready-for-transfer flag stays low, until a parameterised number of reference ticks has passed. A host that follows the normal status handshake therefore just waits. Accesses to the rate and drive-control registers live outside this block. They neither wake it nor cancel an idle count.

Top module: `lp_nap_top`

## Requirements
- R1: After reset the block is in the running state with `osc_en`=1, `core_en`=1, and automatic entry disarmed.
- R2: A mode write with `mode_pd`=1, made while running or while counting idle time, drives `osc_en`, `core_en` and `rqm_out` to 0 from the next clock edge.
- R3: With automatic entry armed and `core_idle` held high, counting starts one cycle after idle is first seen. `osc_en` falls at the edge that samples the IDLE_TICKS-th `ref_tick` pulse of the count.
- R4: During the idle count, any of three events returns the block to running, and a later count starts again from zero: `core_idle` going low, a host access to register code 0 or 1, or any mode write.
- R5: A mode write with `mode_auto`=0 disarms automatic entry. While disarmed, the block never powers down on idle time alone.
- R6: While powered down, a host read or write (`host_rd` or `host_wr` high) with `host_reg` code 0 (status) or 1 (data) sets `osc_en` to 1 at the next edge, while `core_en` stays 0.
- R7: After a wake, `core_en` and the ready flag come back at the edge that samples the STAB_TICKS-th `ref_tick` pulse. Until then, `rqm_out` is 0 whatever `core_rqm` is.
- R8: While powered down, host accesses with `host_rd`/`host_wr` high and `host_reg` code 2 (rate) or 3 (drive control) leave `osc_en` and `core_en` at 0.
- R9: A power-down mode write made while powered down, or during stabilisation, is ignored. A later wake or stabilisation proceeds with unchanged timing.
- R10: While `core_en` is 1, `rqm_out` follows `core_rqm` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse of the slow reference |
| core_idle | input | 1 | Core reports no command activity |
| mode_wr | input | 1 | Mode command strobe |
| mode_auto | input | 1 | Arm (1) or disarm (0) automatic entry, taken on `mode_wr` |
| mode_pd | input | 1 | Power down now, taken on `mode_wr` |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_reg | input | 2 | Register code: 0 status, 1 data, 2 rate, 3 drive control |
| core_rqm | input | 1 | Ready-for-transfer flag from the core |
| osc_en | output | 1 | Oscillator enable |
| core_en | output | 1 | Core logic enable |
| rqm_out | output | 1 | Ready flag as seen by the host |

## Verification
Abort of the idle count is swept over every tick position and over each of the three abort causes. After each abort the bench checks that a full count is needed again, which separates a counter that restarts from one that merely pauses. Wake is tried with every register code under both read and write, which separates the wake-capable codes from the inert ones. Stabilisation is tried with the ready flag held high throughout, so any early release of the flag shows up. Power-down commands are sent in every state, which separates states where the command is accepted from those where it is ignored.

// File: rtl/lp_nap_pkg.sv
package lp_nap_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_COUNT  = 2'd1,
    ST_OFF    = 2'd2,
    ST_SETTLE = 2'd3
  } nap_state_t;

  localparam logic [1:0] REG_STATUS = 2'd0;
  localparam logic [1:0] REG_DATA   = 2'd1;
endpackage

// File: rtl/lp_tick_counter.sv
module lp_tick_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (tick && !done) cnt_q <= cnt_q + 1'b1;
  end

  assign done = !clr && tick && (cnt_q == LAST);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/lp_nap_fsm.sv
module lp_nap_fsm
  import lp_nap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_idle,
  input  logic       mode_wr,
  input  logic       mode_auto,
  input  logic       mode_pd,
  input  logic       wake_hit,
  input  logic       idle_done,
  input  logic       stab_done,
  output nap_state_t state
);
  nap_state_t state_q, state_d;
  logic       auto_q;
  logic       pd_cmd;

  assign pd_cmd = mode_wr && mode_pd;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (pd_cmd)                                  state_d = ST_OFF;
        else if (auto_q && core_idle && !mode_wr && !wake_hit) state_d = ST_COUNT;
      end
      ST_COUNT: begin
        if (pd_cmd)                                  state_d = ST_OFF;
        else if (!core_idle || wake_hit || mode_wr)  state_d = ST_RUN;
        else if (idle_done)                          state_d = ST_OFF;
      end
      ST_OFF: begin
        if (wake_hit)                                state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (stab_done)                               state_d = ST_RUN;
      end
      default:                                       state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      auto_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (mode_wr) auto_q <= mode_auto;
    end
  end

  assign state = state_q;

  p_pd_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN || state_q == ST_COUNT) && pd_cmd) |=> (state_q == ST_OFF));
  p_no_idle_disarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_q |-> (state_q != ST_COUNT));
  p_pd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && !wake_hit) |=> (state_q == ST_OFF));
  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && !pd_cmd && !core_idle) |=> (state_q == ST_RUN));
endmodule

// File: rtl/lp_nap_top.sv
module lp_nap_top
  import lp_nap_pkg::*;
#(
  parameter int IDLE_TICKS = 500,
  parameter int STAB_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       core_idle,
  input  logic       mode_wr,
  input  logic       mode_auto,
  input  logic       mode_pd,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic [1:0] host_reg,
  input  logic       core_rqm,
  output logic       osc_en,
  output logic       core_en,
  output logic       rqm_out
);
  nap_state_t state;
  logic       wake_hit, idle_done, stab_done;

  assign wake_hit = (host_rd || host_wr) &&
                    (host_reg == REG_STATUS || host_reg == REG_DATA);

  lp_nap_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_idle (core_idle),
    .mode_wr   (mode_wr),
    .mode_auto (mode_auto),
    .mode_pd   (mode_pd),
    .wake_hit  (wake_hit),
    .idle_done (idle_done),
    .stab_done (stab_done),
    .state     (state)
  );

  lp_tick_counter #(.LIMIT(IDLE_TICKS)) u_idle_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state != ST_COUNT),
    .tick  (ref_tick),
    .done  (idle_done)
  );

  lp_tick_counter #(.LIMIT(STAB_TICKS)) u_stab_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state != ST_SETTLE),
    .tick  (ref_tick),
    .done  (stab_done)
  );

  assign osc_en  = (state != ST_OFF);
  assign core_en = (state == ST_RUN) || (state == ST_COUNT);
  assign rqm_out = core_rqm && core_en;

  p_core_needs_osc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> osc_en);
  p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && wake_hit) |=> (osc_en && !core_en));
  p_settle_rqm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> !rqm_out);
  p_inert_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !wake_hit) |=> !osc_en);
endmodule

// File: tb/lp_nap_top_tb.sv
module lp_nap_top_tb_top;
  localparam int IDLE = 4;
  localparam int STAB = 3;

  logic clk = 0, rst_n = 0;
  logic ref_tick = 0, core_idle = 0, mode_wr = 0, mode_auto = 0, mode_pd = 0;
  logic host_rd = 0, host_wr = 0, core_rqm = 0;
  logic [1:0] host_reg = 0;
  logic osc_en, core_en, rqm_out;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  lp_nap_top #(.IDLE_TICKS(IDLE), .STAB_TICKS(STAB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .core_idle(core_idle),
    .mode_wr(mode_wr), .mode_auto(mode_auto), .mode_pd(mode_pd),
    .host_rd(host_rd), .host_wr(host_wr), .host_reg(host_reg),
    .core_rqm(core_rqm), .osc_en(osc_en), .core_en(core_en), .rqm_out(rqm_out));

  task automatic clk1();
    @(posedge clk); #1;
  endtask

  task automatic tick();
    ref_tick = 1; clk1(); ref_tick = 0;
  endtask

  task automatic mode(input logic a, input logic p);
    mode_wr = 1; mode_auto = a; mode_pd = p; clk1();
    mode_wr = 0; mode_pd = 0;
  endtask

  task automatic access(input logic wr, input logic [1:0] r);
    host_rd = !wr; host_wr = wr; host_reg = r; clk1();
    host_rd = 0; host_wr = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // wake from powered-down and wait out stabilisation
  task automatic wake_up();
    access(0, 2'd0);
    for (int i = 0; i < STAB; i++) tick();
  endtask

  initial begin
    #200000;
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clk1(); clk1(); rst_n = 1; clk1();
    // R1 reset state
    chk("R1 osc_en", osc_en, 1);
    chk("R1 core_en", core_en, 1);
    // R1/R5 disarmed after reset: idle with many ticks does nothing
    core_idle = 1;
    for (int i = 0; i < IDLE * 3; i++) tick();
    chk("R5 disarmed stays on", osc_en, 1);
    core_idle = 0; clk1();

    // R10 ready passthrough
    for (int v = 0; v < 2; v++) begin
      core_rqm = v[0]; #1;
      chk("R10 rqm follows", rqm_out, v);
    end

    // R2 immediate power-down from running
    core_rqm = 1;
    mode(0, 1);
    chk("R2 osc off", osc_en, 0);
    chk("R2 core off", core_en, 0);
    chk("R2 rqm off", rqm_out, 0);
    // R9 pd while off ignored
    mode(0, 1);
    chk("R9 still off", osc_en, 0);

    // R8 / R6 sweep over register codes and directions
    for (int w = 0; w < 2; w++) begin
      for (int r = 0; r < 4; r++) begin
        access(w[0], r[1:0]);
        if (r >= 2) begin
          chk("R8 inert code osc", osc_en, 0);
          chk("R8 inert code core", core_en, 0);
        end else begin
          chk("R6 wake osc", osc_en, 1);
          chk("R6 wake core held", core_en, 0);
          // R7 stabilisation with rqm forced high
          for (int i = 0; i < STAB - 1; i++) begin
            tick();
            chk("R7 core still off", core_en, 0);
            chk("R7 rqm held", rqm_out, 0);
          end
          tick();
          chk("R7 core back", core_en, 1);
          chk("R7 rqm back", rqm_out, 1);
          mode(0, 1);
        end
      end
    end
    wake_up();
    chk("R7 after wake", core_en, 1);

    // R9 pd during stabilisation ignored
    mode(0, 1);
    access(1, 2'd1);
    tick();
    mode(0, 1);
    chk("R9 settle osc", osc_en, 1);
    for (int i = 0; i < STAB - 2; i++) tick();
    chk("R9 settle core off", core_en, 0);
    tick();
    chk("R9 settle timing kept", core_en, 1);

    // R3 auto entry timing
    mode(1, 0);
    core_idle = 1; clk1();
    for (int i = 0; i < IDLE - 1; i++) tick();
    chk("R3 before last tick", osc_en, 1);
    tick();
    chk("R3 off after last tick", osc_en, 0);
    core_idle = 0;
    wake_up();

    // R4 abort sweep: position x cause
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < IDLE; k++) begin
        core_idle = 1; clk1();
        for (int i = 0; i < k; i++) tick();
        if (c == 0) begin core_idle = 0; clk1(); core_idle = 1; end
        else if (c == 1) access(0, 2'd1);
        else mode(1, 0);
        chk("R4 aborted on", osc_en, 1);
        clk1();  // re-enter count
        for (int i = 0; i < IDLE - 1; i++) tick();
        chk("R4 full restart needed", osc_en, 1);
        tick();
        chk("R4 off after full count", osc_en, 0);
        core_idle = 0;
        wake_up();
      end
    end

    // R2 pd during idle count
    core_idle = 1; clk1(); tick();
    mode(1, 1);
    chk("R2 pd in count", osc_en, 0);
    core_idle = 0;
    wake_up();

    // R5 disarm via mode write
    mode(0, 0);
    core_idle = 1;
    for (int i = 0; i < IDLE * 3; i++) tick();
    chk("R5 disarmed", osc_en, 1);
    core_idle = 0;

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule